// File: doc/BRIEF.md
# PCI Configuration Access Shim

This block answers PCI configuration cycles issued through the port-I/O bus using the classic two-port access scheme. A dword address register at port 0xCF8 selects a bus, device, function and dword register. The data window at 0xCFC then reads or writes the selected configuration dword. Only one function responds: a hard-wired IDE controller. Any other selection looks like an empty slot.

The function carries a minimal type-0 header. It has constant identity and class fields, a command register whose I/O-space enable bit software can set, and a programmable I/O BAR at dword 8 (offset 0x20). Two live outputs leave the block: the I/O-enable bit and the programmed BAR base. The chip's port decoder uses them to claim the 16-byte bus-master register range.

Accesses use a chip select, a write flag, a port address, 32-bit data and four byte strobes. Reads are combinational in the cycle the select is high. Writes commit on the rising clock edge. Reset is synchronous and active high.

Top module: `pci_cfg_shim`

## Requirements
- R1: Synchronous active-high reset clears the address register, the command register and the BAR, so after reset the address register reads 0, `io_space_en` is 0 and `bm_base` is 0.
- R2: A write to port 0xCF8 stores bits 31 (enable), 23:16 (bus), 15:11 (device), 10:8 (function) and 7:2 (dword index). Bits 30:24 and 1:0 always read as 0, and a read of 0xCF8 returns the stored value.
- R3: While bit 31 of the address register is 0, data-window reads return 0xFFFFFFFF and data-window writes change nothing.
- R4: If the bus, device or function is not 0, 1, 1, data-window reads return 0xFFFFFFFF and writes change nothing.
- R5: Dword 0 reads as {device ID 0x0101, vendor ID 0x1D5E}, and writes to it have no effect.
- R6: Dword 2 reads as the constant 0x01018000 (class, subclass, programming interface, revision). Dword 3 reads as 0, which gives header type 0.
- R7: In dword 1 only bits 0 (I/O enable) and 2 (bus master) are writable, and every other bit reads 0. The output `io_space_en` equals bit 0.
- R8: In dword 8 (the BAR) bits 15:4 are writable, bit 0 always reads 1, and every other bit reads 0. The output `bm_base` is the stored bits 15:4 with bits 3:0 equal to zero.
- R9: Writes to the address register or to the data window change only the byte lanes whose strobe is set (strobe i covers bits 8i+7:8i).
- R10: In the matched function, dwords with no implemented register read as 0 and ignore writes.
- R11: An access to any port outside the two dword ports reads 0 and changes no state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| io_sel | input | 1 | Port access valid this cycle |
| io_wr | input | 1 | 1 = write, 0 = read |
| io_addr | input | 16 | Port address |
| io_be | input | 4 | Byte strobes within the dword |
| io_wdata | input | 32 | Write data |
| io_rdata | output | 32 | Read data, combinational |
| io_space_en | output | 1 | Command register I/O enable bit |
| bm_base | output | 16 | Programmed bus-master I/O base |

## Verification
The bench targets the window gating: it writes to the command register while the enable bit is clear, and again while the function number is wrong. A shim that ignored either condition would set `io_space_en` and let the port decoder claim a range that software never opened. It programs the BAR with all ones and with partial strobes. A design that let the low nibble be written, or that lost bit 0, would move `bm_base` off its 16-byte alignment or misreport the space type. It also writes the address register with all ones and checks that the reserved bits return 0 and that a single-lane write leaves the other lanes as they were.

// File: rtl/pci_cfg_shim.sv
module pci_cfg_shim #(
  parameter logic [15:0] ADDR_PORT = 16'h0CF8,
  parameter logic [15:0] DATA_PORT = 16'h0CFC,
  parameter logic [7:0]  TGT_BUS   = 8'd0,
  parameter logic [4:0]  TGT_DEV   = 5'd1,
  parameter logic [2:0]  TGT_FN    = 3'd1,
  parameter logic [15:0] VEN_ID    = 16'h1D5E,
  parameter logic [15:0] DEV_ID    = 16'h0101,
  parameter logic [31:0] CLASS_REV = 32'h01018000,
  parameter logic [15:0] CMD_MASK  = 16'h0005,
  parameter int          BAR_LOG2  = 4
) (
  input  logic        clk,
  input  logic        rst,
  input  logic        io_sel,
  input  logic        io_wr,
  input  logic [15:0] io_addr,
  input  logic [3:0]  io_be,
  input  logic [31:0] io_wdata,
  output logic [31:0] io_rdata,
  output logic        io_space_en,
  output logic [15:0] bm_base
);
  localparam logic [31:0] LATCH_MASK = 32'h80FF_FFFC;
  localparam logic [15:0] BAR_WMASK  = 16'hFFFF << BAR_LOG2;
  localparam logic [5:0]  IDX_ID = 6'd0, IDX_CMD = 6'd1, IDX_CLS = 6'd2,
                          IDX_HDR = 6'd3, IDX_BAR = 6'd8;

  logic [31:0] addr_q;
  logic [15:0] cmd_q;
  logic [15:0] bar_q;

  function automatic logic [31:0] merge(input logic [31:0] old, input logic [31:0] nw,
                                        input logic [3:0] be);
    logic [31:0] r;
    r = old;
    for (int i = 0; i < 4; i++)
      if (be[i]) r[8*i +: 8] = nw[8*i +: 8];
    return r;
  endfunction

  wire asel = io_sel && (io_addr[15:2] == ADDR_PORT[15:2]);
  wire dsel = io_sel && (io_addr[15:2] == DATA_PORT[15:2]);
  wire hit  = addr_q[31] && addr_q[23:16] == TGT_BUS &&
              addr_q[15:11] == TGT_DEV && addr_q[10:8] == TGT_FN;
  wire [5:0] idx = addr_q[7:2];
  wire cfg_wr = dsel && io_wr && hit;

  logic [31:0] cfg_rd;
  always_comb begin
    case (idx)
      IDX_ID:  cfg_rd = {DEV_ID, VEN_ID};
      IDX_CMD: cfg_rd = {16'h0, cmd_q};
      IDX_CLS: cfg_rd = CLASS_REV;
      IDX_HDR: cfg_rd = 32'h0;
      IDX_BAR: cfg_rd = {16'h0, bar_q | 16'h0001};
      default: cfg_rd = 32'h0;
    endcase
  end

  assign io_rdata = (io_sel && !io_wr && asel) ? addr_q :
                    (io_sel && !io_wr && dsel) ? (hit ? cfg_rd : 32'hFFFF_FFFF) :
                    32'h0;

  logic [31:0] cmd_new, bar_new;
  assign cmd_new = merge({16'h0, cmd_q}, io_wdata, io_be);
  assign bar_new = merge({16'h0, bar_q}, io_wdata, io_be);

  always_ff @(posedge clk) begin
    if (rst) begin
      addr_q <= 32'h0;
      cmd_q  <= 16'h0;
      bar_q  <= 16'h0;
    end else begin
      if (asel && io_wr) addr_q <= merge(addr_q, io_wdata, io_be) & LATCH_MASK;
      if (cfg_wr && idx == IDX_CMD) cmd_q <= cmd_new[15:0] & CMD_MASK;
      if (cfg_wr && idx == IDX_BAR) bar_q <= bar_new[15:0] & BAR_WMASK;
    end
  end

  assign io_space_en = cmd_q[0];
  assign bm_base     = bar_q;

  p_reset_clear_r1: assert property (@(posedge clk) rst |=> (addr_q == 32'h0 && !io_space_en && bm_base == 16'h0));
  p_latch_reserved_r2: assert property (@(posedge clk) disable iff (rst) (addr_q[30:24] == 7'h0 && addr_q[1:0] == 2'b00));
  p_closed_window_r3: assert property (@(posedge clk) disable iff (rst)
    (dsel && io_wr && !addr_q[31]) |=> ($stable(io_space_en) && $stable(bm_base)));
  p_absent_reads_r4: assert property (@(posedge clk) disable iff (rst)
    (dsel && !io_wr && !hit) |-> io_rdata == 32'hFFFF_FFFF);
  p_en_needs_write_r7: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && !$stable(io_space_en)) |-> $past(cfg_wr));
  p_base_aligned_r8: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && !$stable(bm_base)) |-> ($past(cfg_wr) && bm_base[BAR_LOG2-1:0] == '0));
  p_other_port_r11: assert property (@(posedge clk) disable iff (rst)
    (io_sel && !asel && !dsel) |-> io_rdata == 32'h0);
endmodule

// File: tb/tb_pci_cfg_shim.sv
module tb_pci_cfg_shim;
  localparam int CLK_PERIOD = 10;
  logic clk = 0, rst = 1, io_sel = 0, io_wr = 0;
  logic [15:0] io_addr = 0;
  logic [3:0] io_be = 0;
  logic [31:0] io_wdata = 0;
  logic [31:0] io_rdata;
  logic io_space_en;
  logic [15:0] bm_base;
  int tests = 0, fails = 0;

  pci_cfg_shim dut (.clk, .rst, .io_sel, .io_wr, .io_addr, .io_be, .io_wdata,
                    .io_rdata, .io_space_en, .bm_base);

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: got %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [15:0] a, input logic [31:0] d, input logic [3:0] be);
    @(negedge clk);
    io_sel = 1; io_wr = 1; io_addr = a; io_wdata = d; io_be = be;
    @(negedge clk);
    io_sel = 0; io_wr = 0;
  endtask

  task automatic rd(input logic [15:0] a, output logic [31:0] d);
    @(negedge clk);
    io_sel = 1; io_wr = 0; io_addr = a; io_be = 4'hF;
    #(CLK_PERIOD/4);
    d = io_rdata;
    @(negedge clk);
    io_sel = 0;
  endtask

  task automatic cfg_rd(input logic [31:0] sel, output logic [31:0] d);
    wr(16'h0CF8, sel, 4'hF);
    rd(16'h0CFC, d);
  endtask

  task automatic t_reset;
    logic [31:0] d;
    rd(16'h0CF8, d);
    check("R1 latch", d, 32'h0);
    check("R1 io_en", {31'h0, io_space_en}, 32'h0);
    check("R1 base", {16'h0, bm_base}, 32'h0);
  endtask

  task automatic t_latch;
    logic [31:0] d;
    wr(16'h0CF8, 32'hFFFF_FFFF, 4'hF);
    rd(16'h0CF8, d);
    check("R2 reserved bits", d, 32'h80FF_FFFC);
    wr(16'h0CF8, 32'h8000_0920, 4'hF);
    rd(16'h0CF8, d);
    check("R2 readback", d, 32'h8000_0920);
  endtask

  task automatic t_closed;
    logic [31:0] d;
    wr(16'h0CF8, 32'h0000_0904, 4'hF);
    wr(16'h0CFC, 32'h0000_0005, 4'hF);
    rd(16'h0CFC, d);
    check("R3 closed read", d, 32'hFFFF_FFFF);
    check("R3 closed write io_en", {31'h0, io_space_en}, 32'h0);
    cfg_rd(32'h8000_0904, d);
    check("R3 cmd untouched", d, 32'h0);
  endtask

  task automatic t_absent;
    logic [31:0] d;
    wr(16'h0CF8, 32'h8000_0804, 4'hF);
    wr(16'h0CFC, 32'h0000_0001, 4'hF);
    rd(16'h0CFC, d);
    check("R4 wrong fn read", d, 32'hFFFF_FFFF);
    check("R4 wrong fn io_en", {31'h0, io_space_en}, 32'h0);
    cfg_rd(32'h8001_0900, d);
    check("R4 wrong bus read", d, 32'hFFFF_FFFF);
    wr(16'h0CF8, 32'h8000_1120, 4'hF);
    wr(16'h0CFC, 32'h0000_FFF0, 4'hF);
    check("R4 wrong dev base", {16'h0, bm_base}, 32'h0);
  endtask

  task automatic t_ids;
    logic [31:0] d;
    wr(16'h0CF8, 32'h8000_0900, 4'hF);
    wr(16'h0CFC, 32'h1234_5678, 4'hF);
    rd(16'h0CFC, d);
    check("R5 id", d, 32'h0101_1D5E);
    cfg_rd(32'h8000_0908, d);
    check("R6 class", d, 32'h0101_8000);
    cfg_rd(32'h8000_090C, d);
    check("R6 header", d, 32'h0);
  endtask

  task automatic t_cmd;
    logic [31:0] d;
    wr(16'h0CF8, 32'h8000_0904, 4'hF);
    wr(16'h0CFC, 32'hFFFF_FFFF, 4'hF);
    rd(16'h0CFC, d);
    check("R7 cmd mask", d, 32'h0000_0005);
    check("R7 io_en set", {31'h0, io_space_en}, 32'h1);
    wr(16'h0CFC, 32'h0000_0004, 4'hF);
    check("R7 io_en clear", {31'h0, io_space_en}, 32'h0);
  endtask

  task automatic t_bar;
    logic [31:0] d;
    wr(16'h0CF8, 32'h8000_0920, 4'hF);
    wr(16'h0CFC, 32'hFFFF_FFFF, 4'hF);
    rd(16'h0CFC, d);
    check("R8 bar ones", d, 32'h0000_FFF1);
    check("R8 base ones", {16'h0, bm_base}, 32'h0000_FFF0);
    wr(16'h0CFC, 32'h0000_C00E, 4'hF);
    rd(16'h0CFC, d);
    check("R8 bar value", d, 32'h0000_C001);
    check("R8 base value", {16'h0, bm_base}, 32'h0000_C000);
  endtask

  task automatic t_strobe;
    logic [31:0] d;
    wr(16'h0CFC, 32'h0000_ABCD, 4'b0010);
    rd(16'h0CFC, d);
    check("R9 bar lane1", d, 32'h0000_AB01);
    check("R9 base lane1", {16'h0, bm_base}, 32'h0000_AB00);
    wr(16'h0CF8, 32'hFFFF_FFFF, 4'b0001);
    rd(16'h0CF8, d);
    check("R9 latch lane0", d, 32'h8000_09FC);
  endtask

  task automatic t_unimpl;
    logic [31:0] d;
    wr(16'h0CF8, 32'h8000_0910, 4'hF);
    wr(16'h0CFC, 32'hFFFF_FFFF, 4'hF);
    rd(16'h0CFC, d);
    check("R10 unimplemented", d, 32'h0);
  endtask

  task automatic t_other;
    logic [31:0] d;
    wr(16'h0CF8, 32'h8000_0920, 4'hF);
    wr(16'h0060, 32'h0000_0000, 4'hF);
    rd(16'h0060, d);
    check("R11 other read", d, 32'h0);
    rd(16'h0CF8, d);
    check("R11 latch kept", d, 32'h8000_0920);
    check("R11 base kept", {16'h0, bm_base}, 32'h0000_AB00);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 0;
    t_reset();
    t_latch();
    t_closed();
    t_absent();
    t_ids();
    t_cmd();
    t_bar();
    t_strobe();
    t_unimpl();
    t_other();
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 20000);
    tests++;
    fails++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule